// File: doc/BRIEF.md
# Stack frame save/restore sequencer

This block executes one compact-encoding frame SAVE or frame RESTORE instruction as a run of single-word memory operations. It receives the 16-bit base instruction word and, when present, a 16-bit extend prefix. From these it decodes three things: which registers take part, how the argument registers are split between the caller's argument area and the callee's static area, and the frame size. SAVE reads each selected register through the register-file read port and stores it. RESTORE loads each word and writes it back through the register-file write port. At the end the stack pointer (r29) is moved by the frame size: down for SAVE, up for RESTORE.

Memory traffic is strictly serial. One request is issued and its response is awaited before the next request goes out. The order of the operations is fixed by the instruction fields, and that order is part of the contract. An unsupported argument-split code makes the block finish at once with an error flag. In that case no memory access is made and the stack pointer is not changed.

Top module: `frame_seq`

## Requirements
- R1: Base word layout, from bit 15 down: `01100`, `100`, direction bit (1 = SAVE, 0 = RESTORE), 3-bit register mask M, 4-bit size field L. Without a prefix, the frame size is 128 bytes when L = 0 and L×8 bytes otherwise. The extra-register count and the argument code are both taken as 0.
- R2: Prefix layout, from bit 15 down: `11110`, 3-bit extra count X, 4-bit size high part H, 4-bit argument code A. With the prefix present, the frame size is {H,L}×8 bytes, so it may be 0.
- R3: On SAVE, the argument-area store count taken from A is: 4–7 → 1, 8–10 → 2, 12–13 → 3, 14 → 4, every other code → 0. These stores write r4, r5, r6, r7 in turn to SP+0, SP+4, SP+8, SP+12 and come before every other access. RESTORE makes no argument-area accesses.
- R4: After the argument stores, each access uses a running address that is first reduced by 4. That address starts at SP for SAVE and at SP+frame size for RESTORE. The order is: r31 if M[2] is set; then the last X entries of the list r30, r23, r22, r21, r20, r19, r18; then r17 if M[0] is set; then r16 if M[1] is set.
- R5: The static registers come last in the sequence, in the order r7, r6, r5, r4. Their count taken from A is: 1, 5, 9, 13 → 1; 2, 6, 10 → 2; 3, 7 → 3; 11 → 4; every other code → 0.
- R6: SAVE ends by writing SP − frame size to r29. RESTORE ends by writing SP + frame size to r29. The arithmetic wraps modulo 2^32.
- R7: A RESTORE load writes its response data to the target register through the write port, in the same cycle in which the response is valid.
- R8: An argument code of 15 produces no memory request and no register write. The sequence then completes with `err` high together with `done`.
- R9: At most one memory transaction is outstanding. No request is issued while a response is still awaited, and every address is word aligned.
- R10: `done` is a one-cycle pulse. After a normal sequence it comes in the cycle following the stack-pointer write. `start` is ignored while the sequencer is busy. After reset `done`, `mem_req` and `rf_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction; accepted only when idle |
| ins_word | input | 16 | Base instruction word |
| ext_word | input | 16 | Extend prefix |
| ext_valid | input | 1 | Prefix present |
| rf_raddr | output | 5 | Register-file read address |
| rf_rdata | input | DW | Register-file read data, combinational |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write address |
| rf_wdata | output | DW | Register-file write data |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Request is a store |
| mem_addr | output | AW | Word address in bytes |
| mem_wdata | output | DW | Store data |
| mem_ack | input | 1 | Response valid |
| mem_rdata | input | DW | Load response data |
| done | output | 1 | Sequence complete pulse |
| err | output | 1 | Unsupported argument code, valid with done |

## Verification
The sweep runs every combination of register mask, extra count and argument code through the prefixed form, for both directions. This checks each entry of the two argument-code tables and every fall-through depth of the extra-register list against an operation queue built by the bench. Directed runs cover the base form with a zero size field (the 128-byte case), both all-zero and all-one prefixed sizes, and a start pulse that arrives mid-sequence. Random runs vary the response latency, which exposes any request issued early or any load written before its data arrives. In RESTORE runs each response returns the bitwise inverse of its address, so a load written to the wrong register or matched to the wrong response shows up in the register model.

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   ins_word,
  input  logic [15:0]   ext_word,
  input  logic          ext_valid,
  output logic [4:0]    rf_raddr,
  input  logic [DW-1:0] rf_rdata,
  output logic          rf_we,
  output logic [4:0]    rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic          err
);
  localparam int NSLOT = 18;
  localparam int SW = $clog2(NSLOT);
  localparam int NARG = 4;
  localparam logic [4:0] SP_REG = 5'd29;

  typedef enum logic [2:0] {S_IDLE, S_SP, S_ISS, S_WAIT, S_SPW, S_FIN} st_t;

  st_t st;
  logic          save_q;
  logic [2:0]    msk_q, xs_q;
  logic [3:0]    ar_q;
  logic [10:0]   fsz_q;
  logic [AW-1:0] sp_q, run_q;
  logic [NSLOT-1:0] pend_q;
  logic [SW-1:0] slot;

  function automatic logic [2:0] arg_cnt(input logic [3:0] a);
    case (a)
      4'd4, 4'd5, 4'd6, 4'd7: arg_cnt = 3'd1;
      4'd8, 4'd9, 4'd10:      arg_cnt = 3'd2;
      4'd12, 4'd13:           arg_cnt = 3'd3;
      4'd14:                  arg_cnt = 3'd4;
      default:                arg_cnt = 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] stat_cnt(input logic [3:0] a);
    case (a)
      4'd1, 4'd5, 4'd9, 4'd13: stat_cnt = 3'd1;
      4'd2, 4'd6, 4'd10:       stat_cnt = 3'd2;
      4'd3, 4'd7:              stat_cnt = 3'd3;
      4'd11:                   stat_cnt = 3'd4;
      default:                 stat_cnt = 3'd0;
    endcase
  endfunction

  function automatic logic [4:0] slot_reg(input logic [SW-1:0] s);
    if (s < SW'(4))       slot_reg = 5'd4 + 5'(s);
    else if (s == SW'(4)) slot_reg = 5'd31;
    else if (s == SW'(5)) slot_reg = 5'd30;
    else if (s < SW'(12)) slot_reg = 5'd29 - 5'(s);
    else if (s < SW'(14)) slot_reg = 5'd29 - 5'(s);
    else                  slot_reg = 5'd21 - 5'(s);
  endfunction

  function automatic logic [NSLOT-1:0] build_mask(input logic sv, input logic [2:0] m,
                                                  input logic [2:0] x, input logic [3:0] a);
    logic [NSLOT-1:0] r;
    r = '0;
    for (int i = 0; i < NARG; i++) begin
      r[i]      = sv && (i < 32'(arg_cnt(a)));
      r[14 + i] = i < 32'(stat_cnt(a));
    end
    r[4] = m[2];
    for (int i = 5; i < 12; i++) r[i] = (i >= 12 - 32'(x));
    r[12] = m[0];
    r[13] = m[1];
    return r;
  endfunction

  wire [2:0]  xs_d = ext_valid ? ext_word[10:8] : 3'd0;
  wire [3:0]  ar_d = ext_valid ? ext_word[3:0] : 4'd0;
  wire [7:0]  fs_units = ext_valid ? {ext_word[7:4], ins_word[3:0]} :
                         (ins_word[3:0] == 4'd0) ? 8'd16 : {4'd0, ins_word[3:0]};

  always_comb begin
    slot = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (pend_q[i]) slot = SW'(i);
  end

  wire           arg_slot = slot < SW'(NARG);
  wire [AW-1:0]  addr_w   = arg_slot ? sp_q + (AW'(slot) << 2) : run_q - AW'(4);
  wire [4:0]     cur_reg  = slot_reg(slot);
  wire [AW-1:0]  sp_new   = save_q ? sp_q - AW'(fsz_q) : sp_q + AW'(fsz_q);

  assign rf_raddr  = (st == S_SP) ? SP_REG : cur_reg;
  assign mem_req   = (st == S_ISS) && (|pend_q);
  assign mem_we    = save_q;
  assign mem_addr  = {addr_w[AW-1:2], 2'b00};
  assign mem_wdata = rf_rdata;
  assign rf_we     = (st == S_SPW) || (st == S_WAIT && mem_ack && !save_q);
  assign rf_waddr  = (st == S_SPW) ? SP_REG : cur_reg;
  assign rf_wdata  = (st == S_SPW) ? sp_new : mem_rdata;
  assign done      = st == S_FIN;
  assign err       = done && (ar_q == 4'hF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      save_q <= 1'b0;
      msk_q  <= '0;
      xs_q   <= '0;
      ar_q   <= '0;
      fsz_q  <= '0;
      sp_q   <= '0;
      run_q  <= '0;
      pend_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          save_q <= ins_word[7];
          msk_q  <= ins_word[6:4];
          xs_q   <= xs_d;
          ar_q   <= ar_d;
          fsz_q  <= {fs_units, 3'b000};
          st     <= S_SP;
        end
        S_SP: begin
          sp_q   <= rf_rdata;
          run_q  <= save_q ? rf_rdata : rf_rdata + AW'(fsz_q);
          pend_q <= build_mask(save_q, msk_q, xs_q, ar_q);
          st     <= (ar_q == 4'hF) ? S_FIN : S_ISS;
        end
        S_ISS: st <= (|pend_q) ? S_WAIT : S_SPW;
        S_WAIT: if (mem_ack) begin
          pend_q[slot] <= 1'b0;
          if (!arg_slot) run_q <= run_q - AW'(4);
          st <= S_ISS;
        end
        S_SPW: st <= S_FIN;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_SP_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> $past(rf_we && rf_waddr == SP_REG)); // R6
  AST_BAD_CODE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SP && ar_q == 4'hF) |=> (done && err && !mem_req && !rf_we)); // R8
  AST_LOAD_ON_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && rf_waddr != SP_REG) |-> (mem_ack && !mem_we)); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && start) |=> $stable(ar_q) && $stable(save_q)); // R10
endmodule

// File: tb/tb_frame_seq.sv
module tb_frame_seq;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, ext_valid = 1'b0;
  logic [15:0] ins_word = '0, ext_word = '0;
  logic [4:0]  rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        rf_we, mem_req, mem_we, done, err;
  logic        mem_ack = 1'b0;

  logic [31:0] regs [0:31];
  logic        ld = 1'b0;
  logic [31:0] base = '0, sp0 = '0;

  int n_chk = 0, n_fail = 0;
  bit hung = 0;

  logic [31:0] exp_addr [0:17];
  logic [4:0]  exp_reg  [0:17];
  string       exp_tag  [0:17];
  int          exp_n;

  always #(CLK_P/2) clk = ~clk;

  frame_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ins_word(ins_word), .ext_word(ext_word),
    .ext_valid(ext_valid), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .err(err)
  );

  function automatic logic [31:0] pat(input int i);
    return base ^ (32'(i) * 32'h0103_0507);
  endfunction

  always @(posedge clk) begin
    if (ld) begin
      for (int i = 0; i < 32; i++) regs[i] <= (i == 29) ? sp0 : pat(i);
    end else if (rf_we) regs[rf_waddr] <= rf_wdata;
  end
  assign rf_rdata = regs[rf_raddr];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, expv);
    end
  endtask

  function automatic int n_args(input logic [3:0] a);
    if (a >= 4 && a <= 7) return 1;
    if (a >= 8 && a <= 10) return 2;
    if (a == 12 || a == 13) return 3;
    if (a == 14) return 4;
    return 0;
  endfunction

  function automatic int n_stat(input logic [3:0] a);
    if (a == 11) return 4;
    if (a == 15) return 0;
    if (a < 8 && a[1:0] == 2'd3) return 3;
    if (a < 12 && a[1:0] == 2'd2) return 2;
    if (a[1:0] == 2'd1) return 1;
    return 0;
  endfunction

  task automatic push(input logic [31:0] a, input int r, input string t);
    exp_addr[exp_n] = a;
    exp_reg[exp_n]  = 5'(r);
    exp_tag[exp_n]  = t;
    exp_n++;
  endtask

  task automatic run_one(input bit dsave, input bit dext, input logic [2:0] dxs,
                         input logic [2:0] dm, input logic [3:0] dar, input logic [3:0] dlo,
                         input logic [3:0] dhi, input int maxd, input bit poke);
    int k, cyc, spw, wait_n, fsb;
    int xl [0:6];
    bit pend, got_done;
    logic [31:0] cur, run, sp_exp;
    logic [3:0] ear;
    logic [2:0] exs;
    if (hung) return;
    xl = '{30, 23, 22, 21, 20, 19, 18};
    ear = dext ? dar : 4'd0;
    exs = dext ? dxs : 3'd0;
    fsb = dext ? 32'({dhi, dlo}) * 8 : (dlo == 0 ? 128 : 32'(dlo) * 8);
    base = $urandom;
    sp0 = $urandom & 32'hFFFF_FFFC;
    exp_n = 0;
    if (ear != 4'hF) begin
      if (dsave) for (int j = 0; j < n_args(ear); j++) push(sp0 + 32'(4 * j), 4 + j, "R3");
      run = dsave ? sp0 : sp0 + 32'(fsb);
      if (dm[2]) begin run -= 4; push(run, 31, "R4"); end
      for (int j = 7 - 32'(exs); j < 7; j++) begin run -= 4; push(run, xl[j], "R4"); end
      if (dm[0]) begin run -= 4; push(run, 17, "R4"); end
      if (dm[1]) begin run -= 4; push(run, 16, "R4"); end
      for (int j = 0; j < n_stat(ear); j++) begin run -= 4; push(run, 7 - j, "R5"); end
    end
    @(negedge clk) ld = 1'b1;
    @(negedge clk) ld = 1'b0;
    ins_word = {5'b01100, 3'b100, dsave, dm, dlo};
    ext_word = {5'b11110, dxs, dhi, dar};
    ext_valid = dext;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    k = 0; pend = 0; spw = -10; cyc = 0; got_done = 0; wait_n = 0; cur = '0;
    while (!got_done) begin
      cyc++;
      if (cyc > 400) begin
        chk(0, "R10", "watchdog, no done", 32'(cyc), 32'd0);
        hung = 1;
        break;
      end
      if (rf_we && rf_waddr == 5'd29) spw = cyc;
      if (done) begin
        got_done = 1;
        chk(err == (ear == 4'hF), "R8", "err with done", 32'(err), 32'(ear == 4'hF));
        chk(k == exp_n, exp_n > 0 ? exp_tag[exp_n-1] : "R8", "operation count", 32'(k), 32'(exp_n));
        if (ear != 4'hF) chk(spw == cyc - 1, "R10", "done after SP write", 32'(spw), 32'(cyc - 1));
      end
      mem_ack = 1'b0;
      if (mem_req) begin
        if (pend) chk(0, "R9", "request while response awaited", mem_addr, 32'd0);
        else if (k >= exp_n) chk(0, ear == 4'hF ? "R8" : "R4", "extra request", mem_addr, 32'd0);
        else begin
          chk(mem_addr == exp_addr[k], exp_tag[k], "address", mem_addr, exp_addr[k]);
          chk(mem_addr[1:0] == 2'b00, "R9", "alignment", mem_addr, exp_addr[k]);
          chk(mem_we == dsave, "R1", "direction", 32'(mem_we), 32'(dsave));
          if (dsave) chk(mem_wdata == pat(exp_reg[k]), exp_tag[k], "store data",
                         mem_wdata, pat(exp_reg[k]));
        end
        pend = 1; wait_n = 1 + int'($urandom % maxd); cur = mem_addr; k++;
      end else if (pend) begin
        wait_n--;
        if (wait_n == 0) begin mem_ack = 1'b1; mem_rdata = ~cur; pend = 0; end
      end
      if (poke && cyc == 3) begin
        ins_word = {5'b01100, 3'b100, ~dsave, ~dm, ~dlo};
        start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
    end
    mem_ack = 1'b0;
    if (!hung) begin
      chk(!done, "R10", "done width", 32'(done), 32'd0);
      sp_exp = (ear == 4'hF) ? sp0 : (dsave ? sp0 - 32'(fsb) : sp0 + 32'(fsb));
      chk(regs[29] == sp_exp, ear == 4'hF ? "R8" : (dext ? "R2" : "R6"), "final SP", regs[29], sp_exp);
      if (!dsave)
        for (int j = 0; j < exp_n; j++)
          chk(regs[exp_reg[j]] == ~exp_addr[j], "R7", "loaded register",
              regs[exp_reg[j]], ~exp_addr[j]);
      if (poke) begin
        repeat (4) @(negedge clk) chk(!mem_req && !done, "R10", "busy start ignored", 32'(mem_req), 32'd0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!done && !mem_req && !rf_we, "R10", "reset outputs", {29'd0, done, mem_req, rf_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run_one(1, 0, 3'd7, 3'd7, 4'd14, 4'd0, 4'd15, 1, 0);
    run_one(0, 0, 3'd0, 3'd7, 4'd0, 4'd0, 4'd0, 1, 0);
    run_one(1, 0, 3'd0, 3'd5, 4'd0, 4'd9, 4'd0, 2, 0);
    run_one(1, 1, 3'd2, 3'd1, 4'd11, 4'd0, 4'd0, 1, 0);
    run_one(0, 1, 3'd7, 3'd7, 4'd3, 4'd15, 4'd15, 3, 0);
    run_one(1, 1, 3'd7, 3'd7, 4'd14, 4'd5, 4'd2, 3, 1);
    run_one(0, 1, 3'd5, 3'd2, 4'd15, 4'd1, 4'd1, 1, 0);
    for (int d = 0; d < 2; d++)
      for (int m = 0; m < 8; m++)
        for (int x = 0; x < 8; x++)
          for (int a = 0; a < 16; a++)
            run_one(d[0], 1, 3'(x), 3'(m), 4'(a), 4'($urandom), 4'($urandom), 1, 0);
    for (int i = 0; i < 300; i++)
      run_one(1'($urandom), 1'($urandom), 3'($urandom), 3'($urandom), 4'($urandom),
              4'($urandom), 4'($urandom), 3, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule